// File: doc/BRIEF.md
# PCIe Root-Complex Clock and Reset Bring-Up Sequencer

This block powers up the reference PLL of a PCIe root complex and releases its resets in a fixed order. A one-cycle start pulse launches the sequence. The block then steps through ten stages. Each stage changes a few control outputs and waits a set number of milliseconds. The millisecond length comes from the parameter `TICKS_PER_MS`, so simulation can use a small value and silicon can use the real clock rate.

The order is as follows:
- Power the PLL up in stages.
- Assert the PHY reset, then the controller reset.
- Pulse the root PERST# low together with the endpoint reset.
- Release the PHY reset, then the controller reset.
- Enable link training and release the endpoint.

After the final 100 ms wait, the block samples the link-up input. It then raises `done_o` for one cycle and reports the result on `link_ok_o`. If the link is down, the PLL goes back to bypass with power-down set, to save power.

Top module: `pcie_bringup_seq`

## Requirements
- R1: After reset the outputs are: bypass=1, power-down=1, PHY reset=1, controller reset=1, `rc_perst_no`=0, `ep_rst_no`=0, LTSSM enable=0. Also `busy_o`, `done_o` and `link_ok_o` are 0.
- R2: A start pulse accepted while idle sets bypass and power-down to 1 and LTSSM enable to 0 at the next clock edge. This state is held for 10 ms. The reset outputs keep their previous values during the first three stages.
- R3: Next, power-down is cleared and held 1 ms. Then bypass is cleared and held 1 ms.
- R4: PHY reset is then asserted and held 10 ms. Then controller reset is asserted and held 10 ms.
- R5: `rc_perst_no` and `ep_rst_no` are then driven low together for 100 ms. Then `rc_perst_no` goes high for 10 ms while `ep_rst_no` stays low.
- R6: PHY reset is released and held 10 ms. Then controller reset is released and held 10 ms.
- R7: LTSSM enable rises, and `ep_rst_no` rises at the same edge. This happens only while both PHY and controller reset are released. `link_up_i` is sampled once, at the end of the 100 ms that follows, and not earlier.
- R8: `done_o` is a single-cycle pulse at exactly 262 ms (262·`TICKS_PER_MS` cycles) after the edge that accepted start. `busy_o` is 1 from that accepting edge until `done_o`.
- R9: If link-up was 1 at the sample, `link_ok_o`=1 and every control output keeps its final value. If it was 0, `link_ok_o`=0, and bypass and power-down return to 1 while the other controls are unchanged.
- R10: A start pulse while `busy_o`=1 is ignored, and the running timing is not disturbed. `link_ok_o` holds its value after `done_o` until the next accepted start, which clears it.
- R11: Every stage lasts exactly its millisecond count times `TICKS_PER_MS` cycles. No stage has an extra or missing cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| link_up_i | input | 1 | Link-up status from the controller |
| pll_bypass_o | output | 1 | PLL bypass, 1 = bypassed |
| pll_pwrdn_o | output | 1 | PLL power-down, 1 = powered down |
| phy_rst_o | output | 1 | PHY reset, 1 = in reset |
| ctl_rst_o | output | 1 | Controller reset, 1 = in reset |
| rc_perst_no | output | 1 | Root-side PERST#, active low |
| ep_rst_no | output | 1 | Endpoint reset, active low |
| ltssm_en_o | output | 1 | Link training enable |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| link_ok_o | output | 1 | Link result of the last sequence |

## Verification
The bench compares every output in every cycle of whole sequences against a model built from cumulative millisecond boundaries. This model catches any stage that is one cycle too long or too short, and any output that changes in the wrong stage.

Link-up is held at the opposite value until the cycle just before the sample edge. A design that samples it early or latches it late therefore reports the wrong result.

A sequence is run after a failed link. This shows that the reset outputs carry over through the first three stages, and that a failure parks only the PLL bits.

A start pulse injected in the middle of a run would restart or shift the timing in a faulty design. That shift shows up at the next stage boundary.

// File: rtl/pcie_seq_pkg.sv
package pcie_seq_pkg;
  localparam int NUM_CTRL  = 7;
  localparam int NUM_STEPS = 10;
  localparam int STEP_W    = $clog2(NUM_STEPS);
  localparam int MS_W      = 7;

  // control vector bits, 1 = asserted
  localparam int B_BYP  = 0;
  localparam int B_PD   = 1;
  localparam int B_PHY  = 2;
  localparam int B_CTL  = 3;
  localparam int B_PRST = 4;
  localparam int B_EP   = 5;
  localparam int B_LTS  = 6;

  typedef logic [NUM_CTRL-1:0] ctrl_t;
  typedef logic [STEP_W-1:0]   step_t;
  typedef logic [MS_W-1:0]     ms_t;

  localparam ctrl_t CTRL_RST  = ctrl_t'(7'b0111111);
  localparam ctrl_t LOW_MASK  = ctrl_t'((1 << B_PRST) | (1 << B_EP));
  localparam ctrl_t PARK_SET  = ctrl_t'((1 << B_BYP) | (1 << B_PD));
  localparam step_t LAST_STEP = step_t'(NUM_STEPS - 1);

  function automatic ms_t step_ms(step_t s);
    case (s)
      4'd0:    return ms_t'(10);
      4'd1:    return ms_t'(1);
      4'd2:    return ms_t'(1);
      4'd5:    return ms_t'(100);
      4'd9:    return ms_t'(100);
      default: return ms_t'(10);
    endcase
  endfunction

  function automatic ctrl_t step_set(step_t s);
    ctrl_t m = '0;
    case (s)
      4'd0: begin m[B_BYP] = 1'b1; m[B_PD] = 1'b1; end
      4'd3: m[B_PHY] = 1'b1;
      4'd4: m[B_CTL] = 1'b1;
      4'd5: begin m[B_PRST] = 1'b1; m[B_EP] = 1'b1; end
      4'd9: m[B_LTS] = 1'b1;
      default: m = '0;
    endcase
    return m;
  endfunction

  function automatic ctrl_t step_clr(step_t s);
    ctrl_t m = '0;
    case (s)
      4'd0: m[B_LTS]  = 1'b1;
      4'd1: m[B_PD]   = 1'b1;
      4'd2: m[B_BYP]  = 1'b1;
      4'd6: m[B_PRST] = 1'b1;
      4'd7: m[B_PHY]  = 1'b1;
      4'd8: m[B_CTL]  = 1'b1;
      4'd9: m[B_EP]   = 1'b1;
      default: m = '0;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/seq_ms_timer.sv
module seq_ms_timer #(
  parameter int TICKS_PER_MS = 1000,
  parameter int MS_W         = 7
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [MS_W-1:0] ms_i,
  output logic            expire_o
);
  localparam int TICK_W = $clog2(TICKS_PER_MS > 1 ? TICKS_PER_MS : 2);
  localparam logic [TICK_W-1:0] TICK_MAX = TICK_W'(TICKS_PER_MS - 1);

  logic [TICK_W-1:0] tick_q;
  logic [MS_W-1:0]   ms_left_q;
  logic              wrap;

  assign wrap     = (tick_q == TICK_MAX);
  assign expire_o = wrap && (ms_left_q == MS_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tick_q    <= '0;
      ms_left_q <= '0;
    end else if (load_i) begin
      tick_q    <= '0;
      ms_left_q <= ms_i;
    end else if (ms_left_q != '0) begin
      if (wrap) begin
        tick_q    <= '0;
        ms_left_q <= ms_left_q - MS_W'(1);
      end else begin
        tick_q <= tick_q + TICK_W'(1);
      end
    end
  end

  AST_LOAD_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> ms_i != '0); // R11
  AST_TICK_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ms_left_q == '0 && !load_i) |=> tick_q == '0); // R11
endmodule

// File: rtl/seq_ctrl_bank.sv
module seq_ctrl_bank #(
  parameter int             W        = 7,
  parameter logic [W-1:0]   RST_VAL  = '0,
  parameter logic [W-1:0]   LOW_MASK = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         apply_i,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] pin_o
);
  logic [W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q <= RST_VAL;
    else if (apply_i) q <= (q & ~clr_i) | set_i;
  end

  for (genvar i = 0; i < W; i++) begin : g_pol
    if (LOW_MASK[i]) begin : g_low
      assign pin_o[i] = ~q[i];
    end else begin : g_high
      assign pin_o[i] = q[i];
    end
  end
endmodule

// File: rtl/pcie_bringup_seq.sv
module pcie_bringup_seq
  import pcie_seq_pkg::*;
#(
  parameter int TICKS_PER_MS = 100000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic link_up_i,
  output logic pll_bypass_o,
  output logic pll_pwrdn_o,
  output logic phy_rst_o,
  output logic ctl_rst_o,
  output logic rc_perst_no,
  output logic ep_rst_no,
  output logic ltssm_en_o,
  output logic busy_o,
  output logic done_o,
  output logic link_ok_o
);
  logic  busy_q, done_q, link_ok_q;
  step_t step_q, nxt_step;
  logic  launch, advance, finish, tmr_expire;
  logic  apply, load;
  ctrl_t set_m, clr_m, pins;
  ms_t   load_ms;

  assign launch   = !busy_q && start_i;
  assign finish   = busy_q && tmr_expire && (step_q == LAST_STEP);
  assign advance  = busy_q && tmr_expire && (step_q != LAST_STEP);
  assign nxt_step = launch ? step_t'(0) : step_t'(step_q + step_t'(1));
  assign load     = launch || advance;
  assign load_ms  = step_ms(nxt_step);
  assign apply    = load || (finish && !link_up_i);
  assign set_m    = finish ? PARK_SET : step_set(nxt_step);
  assign clr_m    = finish ? ctrl_t'(0) : step_clr(nxt_step);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
      link_ok_q <= 1'b0;
      step_q    <= '0;
    end else begin
      done_q <= 1'b0;
      if (launch) begin
        busy_q    <= 1'b1;
        link_ok_q <= 1'b0;
        step_q    <= '0;
      end else if (advance) begin
        step_q <= nxt_step;
      end else if (finish) begin
        busy_q    <= 1'b0;
        done_q    <= 1'b1;
        link_ok_q <= link_up_i;
      end
    end
  end

  seq_ms_timer #(.TICKS_PER_MS(TICKS_PER_MS), .MS_W(MS_W)) u_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .ms_i    (load_ms),
    .expire_o(tmr_expire)
  );

  seq_ctrl_bank #(.W(NUM_CTRL), .RST_VAL(CTRL_RST), .LOW_MASK(LOW_MASK)) u_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .apply_i(apply),
    .set_i  (set_m),
    .clr_i  (clr_m),
    .pin_o  (pins)
  );

  assign pll_bypass_o = pins[B_BYP];
  assign pll_pwrdn_o  = pins[B_PD];
  assign phy_rst_o    = pins[B_PHY];
  assign ctl_rst_o    = pins[B_CTL];
  assign rc_perst_no  = pins[B_PRST];
  assign ep_rst_no    = pins[B_EP];
  assign ltssm_en_o   = pins[B_LTS];
  assign busy_o       = busy_q;
  assign done_o       = done_q;
  assign link_ok_o    = link_ok_q;

  AST_LTSSM_AFTER_REL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ltssm_en_o |-> (!phy_rst_o && !ctl_rst_o)); // R7
  AST_PERST_WITH_EP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rc_perst_no |-> !ep_rst_no); // R5
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R8
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o); // R8
  AST_FAIL_PARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !link_ok_o) |-> (pll_bypass_o && pll_pwrdn_o)); // R9
  AST_BUSY_START_IGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && !tmr_expire) |=> (busy_o && step_q == $past(step_q))); // R10
  AST_LINK_OK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i && !done_o) |=> $stable(link_ok_o)); // R10
endmodule

// File: tb/sim_pcie_bringup_seq.sv
module sim_pcie_bringup_seq;
  localparam int T     = 3;
  localparam int TOTAL = 262 * T;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, link_up = 1'b0;
  logic byp, pd, phy, ctl, perst_n, ep_n, lts, busy, done, lok;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  pcie_bringup_seq #(.TICKS_PER_MS(T)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .link_up_i(link_up),
    .pll_bypass_o(byp), .pll_pwrdn_o(pd), .phy_rst_o(phy), .ctl_rst_o(ctl),
    .rc_perst_no(perst_n), .ep_rst_no(ep_n), .ltssm_en_o(lts),
    .busy_o(busy), .done_o(done), .link_ok_o(lok)
  );

  // vector bits {lts, ep_n, perst_n, ctl, phy, pd, byp} at port level
  function automatic logic [6:0] model(int n, logic [6:0] prev, logic lk);
    logic [6:0] v = prev;
    int ms = n / T;
    v[0] = 1'b1; v[1] = 1'b1; v[6] = 1'b0;
    if (ms >= 10)  v[1] = 1'b0;
    if (ms >= 11)  v[0] = 1'b0;
    if (ms >= 12)  v[2] = 1'b1;
    if (ms >= 22)  v[3] = 1'b1;
    if (ms >= 32)  begin v[4] = 1'b0; v[5] = 1'b0; end
    if (ms >= 132) v[4] = 1'b1;
    if (ms >= 142) v[2] = 1'b0;
    if (ms >= 152) v[3] = 1'b0;
    if (ms >= 162) begin v[6] = 1'b1; v[5] = 1'b1; end
    if (ms >= 262 && !lk) begin v[0] = 1'b1; v[1] = 1'b1; end
    return v;
  endfunction

  function automatic string req_of(int n);
    int ms = n / T;
    if (ms < 10)  return "R2";
    if (ms < 12)  return "R3";
    if (ms < 32)  return "R4";
    if (ms < 142) return "R5";
    if (ms < 162) return "R6";
    if (ms < 262) return "R7";
    return "R9";
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_run(input logic lk, input logic mid_start, inout logic [6:0] prev);
    logic [6:0] act;
    link_up = !lk;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    for (int n = 0; n <= TOTAL + 3; n++) begin
      act = {lts, ep_n, perst_n, ctl, phy, pd, byp};
      chk(req_of(n), 32'(act), 32'(model(n, prev, lk)));
      chk("R8", 32'({busy, done}), 32'({n < TOTAL, n == TOTAL}));
      chk("R10", 32'(lok), 32'(n >= TOTAL ? lk : 1'b0));
      if (n == TOTAL - 1) link_up = lk;
      start = mid_start && (n == 50 || n == 12 * T - 1);
      @(negedge clk);
    end
    start = 1'b0;
    // link_ok held with link_up flipped while idle (R10)
    link_up = !lk;
    repeat (5) @(negedge clk);
    chk("R10", 32'(lok), 32'(lk));
    chk("R11", 32'({lts, ep_n, perst_n, ctl, phy, pd, byp}), 32'(model(TOTAL, prev, lk)));
    prev = model(TOTAL, prev, lk);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [6:0] prev;
    repeat (3) @(negedge clk);
    chk("R1", 32'({lts, ep_n, perst_n, ctl, phy, pd, byp, busy, done, lok}), 32'({7'b0001111, 3'b000}));
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", 32'({lts, ep_n, perst_n, ctl, phy, pd, byp, busy, done, lok}), 32'({7'b0001111, 3'b000}));
    prev = 7'b0001111;
    do_run(1'b0, 1'b0, prev); // R9 fail path from reset state
    do_run(1'b1, 1'b1, prev); // R10 mid-run starts ignored, pass path
    do_run(1'b1, 1'b0, prev); // R2 reset bits carried from a passed run
    do_run(1'b0, 1'b1, prev); // R11 timing again, fail after pass
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule